// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block sits on the processor side of the bus. It turns a pending interrupt request that the mask allows into one complete acknowledge bus cycle. At an instruction boundary it checks the incoming request level against the current mask and accepts the request if the mask allows it. It then asks the stacking datapath to save processor state and waits for that to finish. After that it pulses a clear of the page-extension field, and only then opens a CPU-space acknowledge cycle.

During the acknowledge cycle the block drives a fixed function code and a fixed address pattern, with the accepted level placed in three address bits. The level seen on those bits is written back into the interrupt-priority field of the status register. The cycle ends in one of three ways: a responder supplies a vector with termination, a bus error arrives, or the block's own spurious monitor times out. A bus error or a timeout yields the spurious vector 8'h18 instead of a fetched one.

Top module: `irq_ack_seq`

## Requirements
- R1: A request is accepted only when `insn_boundary` is high in the idle state, `irq_level` is non-zero, and `irq_level` is greater than `cur_mask`, or `irq_level` equals 7 whatever the mask.
- R2: `stack_req` is high for exactly one cycle, one clock after acceptance. The sequencer then waits for `stack_done` before going further.
- R3: `pk_clr` pulses for one cycle in the clock after `stack_done` is seen. `ack_active` rises in the very next cycle and never before `pk_clr`.
- R4: While `ack_active` is high, `fc` is 3'b111, `addr[23:4]` are all ones and `addr[0]` is 1. Outside the acknowledge cycle, `fc` and `addr` are zero.
- R5: During the acknowledge cycle, `addr[3:1]` carries the accepted level. `sr_ip_wr` pulses in the first acknowledge cycle, and `sr_ip_val` equals `addr[3:1]`.
- R6: `vec_term` sampled high during the acknowledge cycle ends it. In the next cycle `done` is high for one cycle, `vec_out` equals the captured `vec_in`, and `spurious` is 0. `vec_term` wins over `berr_in` and over the timeout in the same cycle.
- R7: `berr_in` sampled high during the acknowledge cycle, without `vec_term`, ends the cycle with `spurious`=1, `vec_out`=8'h18 and `mon_berr`=0.
- R8: If nothing answers within TIMEOUT acknowledge cycles (default 16), the monitor ends the cycle after exactly TIMEOUT cycles with `spurious`=1, `mon_berr`=1 and `vec_out`=8'h18. An answer in the last of those cycles still counts.
- R9: During and right after reset, all outputs are zero and the sequencer is idle.
- R10: While a sequence is in progress, changes on `irq_level`, `cur_mask` and `insn_boundary` are ignored. No new `stack_req` appears and `addr[3:1]` keeps the accepted level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_level | input | 3 | Pending request level, 0 = none |
| cur_mask | input | 3 | Current interrupt mask |
| insn_boundary | input | 1 | Instruction boundary reached, higher exceptions done |
| stack_req | output | 1 | One-cycle request to stack processor state |
| stack_done | input | 1 | Stacking finished |
| pk_clr | output | 1 | One-cycle clear of the page-extension field |
| ack_active | output | 1 | Acknowledge bus cycle in progress |
| fc | output | 3 | Function code |
| addr | output | 24 | Address bus |
| sr_ip_wr | output | 1 | Write strobe for the status-register priority field |
| sr_ip_val | output | 3 | Value for the priority field, taken from addr[3:1] |
| vec_term | input | 1 | Responder supplies vector and termination |
| vec_in | input | 8 | Vector from the responder |
| berr_in | input | 1 | Bus error during the acknowledge cycle |
| done | output | 1 | One-cycle end-of-sequence strobe |
| vec_out | output | 8 | Resulting vector number |
| spurious | output | 1 | Sequence ended as a spurious interrupt |
| mon_berr | output | 1 | The spurious monitor forced the bus error |

## Verification
The acceptance gate is tried with levels above, equal to and below the mask, with level 0, and with level 7 over a mask of 7; together these separate a greater-than compare from greater-or-equal and show the non-maskable override. Each accepted request is ended by a vector at different delays, by a bus error, and by silence. A vector on the last allowed cycle separates an off-by-one timeout from a correct one, and comparing the bus-error case with the timeout case shows which source raised the spurious result. A directed run keeps a level-7 request and a boundary asserted through a whole sequence to show that inputs are ignored while busy.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ADDR_W   = 24;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam logic [2:0] FC_CPU_SPACE = 3'b111;
  localparam logic [VEC_W-1:0] SPUR_VEC = 8'h18;
  localparam logic [LVL_W-1:0] NMI_LVL  = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STK, ST_WAIT, ST_PK, ST_ACK, ST_RES
  } seq_state_t;

  // Request passes the mask: non-zero and above mask, or the top level.
  function automatic logic lvl_passes(input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] mask);
    return (lvl != '0) && ((lvl > mask) || (lvl == NMI_LVL));
  endfunction

  // CPU-space acknowledge address: ones above, level in [3:1], bit 0 set.
  function automatic logic [ADDR_W-1:0] ack_address(input logic [LVL_W-1:0] lvl);
    return {{(ADDR_W-LVL_W-1){1'b1}}, lvl, 1'b1};
  endfunction
endpackage

// File: rtl/irq_ack_gate.sv
module irq_ack_gate
  import irq_ack_pkg::*;
(
  input  logic             idle,
  input  logic             boundary,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] mask,
  output logic             take
);
  always_comb take = idle && boundary && lvl_passes(level, mask);
endmodule

// File: rtl/irq_spur_mon.sv
module irq_spur_mon #(
  parameter int TIMEOUT = 16,
  localparam int CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic answered,
  output logic first,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    first   = run && (cnt_q == '0);
    expired = run && (cnt_q == LAST) && !answered;
  end
endmodule

// File: rtl/irq_ack_bus.sv
module irq_ack_bus
  import irq_ack_pkg::*;
(
  input  logic              active,
  input  logic [LVL_W-1:0]  level,
  output logic [2:0]        fc,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    fc   = active ? FC_CPU_SPACE : 3'b000;
    addr = active ? ack_address(level) : '0;
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  irq_level,
  input  logic [2:0]  cur_mask,
  input  logic        insn_boundary,
  output logic        stack_req,
  input  logic        stack_done,
  output logic        pk_clr,
  output logic        ack_active,
  output logic [2:0]  fc,
  output logic [23:0] addr,
  output logic        sr_ip_wr,
  output logic [2:0]  sr_ip_val,
  input  logic        vec_term,
  input  logic [7:0]  vec_in,
  input  logic        berr_in,
  output logic        done,
  output logic [7:0]  vec_out,
  output logic        spurious,
  output logic        mon_berr
);
  seq_state_t       state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic             spur_q, mberr_q;

  // Named internal events
  logic take, mon_first, mon_expired, answered;

  irq_ack_gate u_gate (
    .idle(state_q == ST_IDLE), .boundary(insn_boundary),
    .level(irq_level), .mask(cur_mask), .take(take)
  );

  assign answered = vec_term || berr_in;

  irq_spur_mon #(.TIMEOUT(TIMEOUT)) u_mon (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_ACK),
    .answered(answered), .first(mon_first), .expired(mon_expired)
  );

  irq_ack_bus u_bus (
    .active(state_q == ST_ACK), .level(lvl_q), .fc(fc), .addr(addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      vec_q   <= '0;
      spur_q  <= 1'b0;
      mberr_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_STK;
          lvl_q   <= irq_level;
        end
        ST_STK:  state_q <= ST_WAIT;
        ST_WAIT: if (stack_done) state_q <= ST_PK;
        ST_PK:   state_q <= ST_ACK;
        ST_ACK: begin
          if (vec_term) begin
            state_q <= ST_RES; vec_q <= vec_in; spur_q <= 1'b0; mberr_q <= 1'b0;
          end else if (berr_in) begin
            state_q <= ST_RES; vec_q <= SPUR_VEC; spur_q <= 1'b1; mberr_q <= 1'b0;
          end else if (mon_expired) begin
            state_q <= ST_RES; vec_q <= SPUR_VEC; spur_q <= 1'b1; mberr_q <= 1'b1;
          end
        end
        ST_RES:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stack_req  = (state_q == ST_STK);
    pk_clr     = (state_q == ST_PK);
    ack_active = (state_q == ST_ACK);
    sr_ip_wr   = mon_first;
    sr_ip_val  = mon_first ? addr[3:1] : '0;
    done       = (state_q == ST_RES);
    vec_out    = done ? vec_q : '0;
    spurious   = done && spur_q;
    mon_berr   = done && mberr_q;
  end
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stack_req,
  input logic        pk_clr,
  input logic        ack_active,
  input logic [2:0]  fc,
  input logic [23:0] addr,
  input logic        sr_ip_wr,
  input logic [2:0]  sr_ip_val,
  input logic        done,
  input logic [7:0]  vec_out,
  input logic        spurious,
  input logic        mon_berr,
  input logic        mon_expired
);
  p_stack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stack_req |=> !stack_req);

  p_pk_before_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_active) |-> $past(pk_clr));

  p_cpu_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_active |-> (fc == 3'b111 && addr[23:4] == 20'hFFFFF && addr[0]));

  p_bus_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_active |-> (fc == 3'b000 && addr == 24'h0));

  p_ip_from_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_ip_wr |-> (ack_active && sr_ip_val == addr[3:1]));

  p_spur_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && spurious) |-> vec_out == 8'h18);

  p_timeout_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mon_expired |=> (done && spurious && mon_berr && !ack_active));

  p_done_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ack_active));
endmodule

bind irq_ack_seq irq_ack_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stack_req(stack_req), .pk_clr(pk_clr),
  .ack_active(ack_active), .fc(fc), .addr(addr), .sr_ip_wr(sr_ip_wr),
  .sr_ip_val(sr_ip_val), .done(done), .vec_out(vec_out),
  .spurious(spurious), .mon_berr(mon_berr), .mon_expired(mon_expired)
);

// File: tb/irq_ack_seq_tb_top.sv
module irq_ack_seq_tb_top;
  localparam int TO = 16;
  localparam int NV = 10;
  // {level[3], mask[3], taken[1], kind[2] (0 vector,1 berr,2 silent), delay[5], vec[8]}
  localparam logic [21:0] VECS [NV] = '{
    {3'd3, 3'd1, 1'b1, 2'd0, 5'd2,  8'h40},
    {3'd5, 3'd4, 1'b1, 2'd0, 5'd0,  8'h41},
    {3'd7, 3'd7, 1'b1, 2'd0, 5'd5,  8'h42},
    {3'd2, 3'd2, 1'b0, 2'd0, 5'd0,  8'h00},
    {3'd1, 3'd6, 1'b0, 2'd0, 5'd0,  8'h00},
    {3'd0, 3'd0, 1'b0, 2'd0, 5'd0,  8'h00},
    {3'd4, 3'd0, 1'b1, 2'd1, 5'd3,  8'h99},
    {3'd6, 3'd2, 1'b1, 2'd2, 5'd0,  8'h00},
    {3'd1, 3'd0, 1'b1, 2'd0, 5'd15, 8'h55},
    {3'd7, 3'd0, 1'b1, 2'd0, 5'd1,  8'h77}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] irq_level = '0, cur_mask = '0;
  logic insn_boundary = 1'b0, stack_done = 1'b0, vec_term = 1'b0, berr_in = 1'b0;
  logic [7:0] vec_in = '0;
  logic stack_req, pk_clr, ack_active, sr_ip_wr, done, spurious, mon_berr;
  logic [2:0] fc, sr_ip_val;
  logic [23:0] addr;
  logic [7:0] vec_out;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_ack_seq #(.TIMEOUT(TO)) dut_i (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [2:0] lvl, input logic [2:0] msk, input logic taken,
                         input logic [1:0] kind, input int dly, input logic [7:0] v,
                         input logic hold_busy);
    logic seen = 1'b0;
    int n = 0;
    logic [7:0] ev;
    @(negedge clk);
    irq_level = lvl; cur_mask = msk; insn_boundary = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (stack_req) begin seen = 1'b1; break; end
    end
    chk(seen == taken, "R1 accept", seen, taken);
    if (!hold_busy) begin irq_level = '0; insn_boundary = 1'b0; end
    else begin irq_level = 3'd7; cur_mask = 3'd0; end
    if (!taken) return;
    @(negedge clk);
    chk(!stack_req, "R2 stack pulse width", stack_req, 0);
    repeat (2) begin
      @(negedge clk);
      chk(!pk_clr && !ack_active, "R2 wait for stack_done", pk_clr, 0);
    end
    stack_done = 1'b1;
    @(negedge clk);
    chk(pk_clr && !ack_active, "R3 pk_clr before ack", {pk_clr, ack_active}, 2);
    stack_done = 1'b0;
    @(negedge clk);
    chk(ack_active && fc == 3'b111, "R4 cpu space fc", fc, 7);
    chk(addr == {20'hFFFFF, lvl, 1'b1}, "R5 ack address", addr, {20'hFFFFF, lvl, 1'b1});
    chk(sr_ip_wr && sr_ip_val == lvl, "R5 ip latch", sr_ip_val, lvl);
    for (int i = 0; i < 40; i++) begin
      if (ack_active) begin
        if (hold_busy) chk(!stack_req && addr[3:1] == lvl, "R10 busy ignores request", addr[3:1], lvl);
        vec_term = (kind == 2'd0) && (n == dly);
        berr_in  = (kind == 2'd1) && (n == dly);
        vec_in   = v;
        n++;
      end
      @(negedge clk);
      vec_term = 1'b0; berr_in = 1'b0;
      if (done) break;
    end
    if (hold_busy) begin irq_level = '0; insn_boundary = 1'b0; end
    ev = (kind == 2'd0) ? v : 8'h18;
    chk(done, "R6 done strobe", done, 1);
    chk(vec_out == ev, kind == 0 ? "R6 vector" : (kind == 1 ? "R7 vector" : "R8 vector"), vec_out, ev);
    chk(spurious == (kind != 0), kind == 1 ? "R7 spurious" : "R6 spurious", spurious, kind != 0);
    chk(mon_berr == (kind == 2), "R8 monitor berr", mon_berr, kind == 2);
    chk(n == ((kind == 2) ? TO : dly + 1), "R8 ack length", n, (kind == 2) ? TO : dly + 1);
    chk(fc == 0 && addr == 0, "R4 bus quiet", addr, 0);
    @(negedge clk);
    chk(!done && !stack_req, "R10 no retrigger", {done, stack_req}, 0);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    insn_boundary = 1'b1; irq_level = 3'd7;
    repeat (3) @(negedge clk);
    chk({stack_req, pk_clr, ack_active, done, fc, addr} == '0, "R9 in reset", addr, 0);
    rst_n = 1'b1;
    insn_boundary = 1'b0; irq_level = '0;
    @(negedge clk);
    chk({stack_req, pk_clr, ack_active, done, spurious, vec_out, sr_ip_wr} == '0,
        "R9 after reset", vec_out, 0);
    for (int k = 0; k < NV; k++)
      run_seq(VECS[k][21:19], VECS[k][18:16], VECS[k][15], VECS[k][14:13],
              int'(VECS[k][12:8]), VECS[k][7:0], 1'b0);
    // R10: request held high and level raised during the whole sequence
    run_seq(3'd2, 3'd0, 1'b1, 2'd0, 3, 8'h61, 1'b1);
    // R6: vector and bus error in the same cycle, vector wins
    @(negedge clk); irq_level = 3'd3; insn_boundary = 1'b1;
    @(negedge clk); irq_level = '0; insn_boundary = 1'b0;
    repeat (2) @(negedge clk);
    stack_done = 1'b1; @(negedge clk); stack_done = 1'b0;
    @(negedge clk);
    vec_term = 1'b1; berr_in = 1'b1; vec_in = 8'h3C;
    @(negedge clk); vec_term = 1'b0; berr_in = 1'b0;
    chk(done && !spurious && vec_out == 8'h3C, "R6 vector over berr", vec_out, 8'h3C);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule